// File: doc/BRIEF.md
# Power-Management Function Base Decoder

This block is the configuration-space side of a power-management PCI function. It accepts dword-addressed configuration writes with per-byte enables, keeps the function's device-specific registers, and uses two of them as relocatable I/O base registers. From those bases it decodes incoming I/O accesses into two windows. One is a 128-byte power-management window and the other is a 16-byte SMBus window. For each window it produces a hit flag and the offset inside the window.

The timer, event and SMBus logic sit outside this block and connect to the hit and offset outputs. Base registers are cleaned up on every write that touches them: the low address bits are cleared to give the window alignment, and bit 0 always reads as 1. Each window has its own enable bit, and the two enable bits sit in different registers. Decode is combinational from the stored registers, so an access in the cycle after a configuration write already sees the new base and enable.

Top module: `pmf_base_decoder`

## Requirements
- R1: After reset, the dwords at configuration byte offsets 0x48 and 0x90 read 0x00000001. Every other dword from 0x40 to 0xFF reads zero. No I/O access produces a hit in either window.
- R2: Dword 0x00 reads {device id, vendor id}, dword 0x08 reads {class code, revision}, and the status half of dword 0x04 (bits 31:16) always reads 0x0280. Only the command half (bits 15:0) of dword 0x04 is writable. Writes to any other header dword (0x00–0x3C) have no effect.
- R3: A write to dword 0x48 with any byte enable first merges the enabled bytes into the old value. The stored result is then that value ANDed with 0x0000FF80, with bit 0 set.
- R4: A write to dword 0x90 with any byte enable stores the merged value ANDed with 0x0000FFF0, with bit 0 set.
- R5: When byte 0xD2 is written (dword 0xD0, byte enable 2), only its low 4 bits are stored and bits 7:4 read zero.
- R6: The power-management window hits when bit 7 of byte 0x41 (dword 0x40, bit 15) is set, an access strobe is active, and io_addr[15:7] equals bits 15:7 of dword 0x48. pm_off then equals io_addr[6:0].
- R7: The SMBus window hits when bit 0 of byte 0xD2 (dword 0xD0, bit 16) is set, a strobe is active, and io_addr[15:4] equals bits 15:4 of dword 0x90. smb_off then equals io_addr[3:0].
- R8: I/O writes that hit the power-management window change no register, and reads that hit it return pm_rdata = 0.
- R9: For device-specific dwords outside the base and 0xD2 rules, only the bytes whose enables are set change.
- R10: A configuration write takes effect on the decode in the very next cycle.
- R11: With neither io_rd nor io_wr asserted, both hit outputs are low.
- R12: A configuration read returns the addressed dword on cfg_rdata one cycle later, qualified by cfg_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_dw_addr | input | 6 | Configuration dword address (byte offset / 4) |
| cfg_be | input | 4 | Configuration byte enables |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rvalid | output | 1 | Read data valid, one cycle after cfg_rd |
| cfg_rdata | output | 32 | Configuration read data |
| io_addr | input | 16 | I/O access address |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| pm_hit | output | 1 | Power-management window hit |
| pm_off | output | 7 | Offset inside power-management window |
| smb_hit | output | 1 | SMBus window hit |
| smb_off | output | 4 | Offset inside SMBus window |
| pm_rdata | output | 8 | Read data for power-management window accesses |

## Verification
Several properties are checked by assertions on every cycle. These are the shape of any read-back base value (alignment bits clear, bit 0 set, upper half zero), the clean upper nibble of byte 0xD2, the fixed status field, and the absence of hits without a strobe. Another assertion holds that hits stay steady while neither the address, the strobes nor the configuration change. Other behaviour only the bench scenarios can show. This covers the exact merged values after partial byte-enable writes, the window edges (last byte in, first byte out), and that a new base or enable reaches the decode in the next cycle. It also covers that header and window writes leave state untouched.

// File: rtl/pmf_pkg.sv
package pmf_pkg;

  // Merge enabled bytes of a write into the old dword.
  function automatic logic [31:0] merge_bytes(input logic [31:0] old_v,
                                              input logic [31:0] wr_v,
                                              input logic [3:0]  be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) begin
      r[b*8 +: 8] = be[b] ? wr_v[b*8 +: 8] : old_v[b*8 +: 8];
    end
    return r;
  endfunction

  // Apply the alignment mask and force the I/O-space bit.
  function automatic logic [31:0] clean_base(input logic [31:0] v,
                                             input logic [31:0] mask);
    return (v & mask) | 32'h1;
  endfunction

  // Address falls inside an aligned window of 2**span bytes.
  function automatic logic in_window(input logic [15:0] addr,
                                     input logic [15:0] base,
                                     input int          span);
    logic [15:0] upper;
    upper = 16'hFFFF << span;
    return (addr & upper) == (base & upper);
  endfunction

endpackage

// File: rtl/pmf_cfg_regs.sv
module pmf_cfg_regs
  import pmf_pkg::*;
#(
  parameter int          CFG_DW_W   = 6,
  parameter int          HDR_DWORDS = 16,
  parameter int          PM_SPAN    = 7,
  parameter int          SMB_SPAN   = 4,
  parameter int          PM_BASE_DW = 18,
  parameter int          SMB_BASE_DW = 36,
  parameter int          PM_EN_DW   = 16,
  parameter int          SMB_CTL_DW = 52,
  parameter logic [15:0] VENDOR_ID  = 16'h1D0F,
  parameter logic [15:0] DEVICE_ID  = 16'h3057,
  parameter logic [23:0] CLASS_CODE = 24'h068000,
  parameter logic [7:0]  REV_ID     = 8'h40,
  parameter logic [15:0] STATUS_VAL = 16'h0280
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic                cfg_rd,
  input  logic [CFG_DW_W-1:0] cfg_dw_addr,
  input  logic [3:0]          cfg_be,
  input  logic [31:0]         cfg_wdata,
  output logic                cfg_rvalid,
  output logic [31:0]         cfg_rdata,
  output logic [15:0]         pm_base,
  output logic                pm_en,
  output logic [15:0]         smb_base,
  output logic                smb_en
);
  localparam int TOTAL_DW   = 1 << CFG_DW_W;
  localparam int DEV_DWORDS = TOTAL_DW - HDR_DWORDS;
  localparam int IDX_W      = $clog2(DEV_DWORDS);
  localparam logic [31:0] PM_MASK  = 32'h0000FFFF & (32'hFFFFFFFF << PM_SPAN);
  localparam logic [31:0] SMB_MASK = 32'h0000FFFF & (32'hFFFFFFFF << SMB_SPAN);
  localparam int PM_EN_IDX  = PM_EN_DW - HDR_DWORDS;
  localparam int SMB_EN_IDX = SMB_CTL_DW - HDR_DWORDS;
  localparam int PM_B_IDX   = PM_BASE_DW - HDR_DWORDS;
  localparam int SMB_B_IDX  = SMB_BASE_DW - HDR_DWORDS;

  logic [31:0] dev_q [DEV_DWORDS];
  logic [15:0] cmd_q;

  // Event wires
  logic                in_dev;
  logic [CFG_DW_W-1:0] dev_off;
  logic [IDX_W-1:0]    dev_idx;
  logic                dev_wr;
  logic                cmd_wr;

  assign in_dev  = int'(cfg_dw_addr) >= HDR_DWORDS;
  assign dev_off = cfg_dw_addr - CFG_DW_W'(HDR_DWORDS);
  assign dev_idx = dev_off[IDX_W-1:0];
  assign dev_wr  = cfg_wr && in_dev;
  assign cmd_wr  = cfg_wr && (cfg_dw_addr == CFG_DW_W'(1));

  function automatic logic [31:0] next_word(input logic [CFG_DW_W-1:0] dw,
                                            input logic [31:0] old_v,
                                            input logic [31:0] wr_v,
                                            input logic [3:0]  be);
    logic [31:0] m;
    m = merge_bytes(old_v, wr_v, be);
    if (int'(dw) == PM_BASE_DW)  m = clean_base(m, PM_MASK);
    if (int'(dw) == SMB_BASE_DW) m = clean_base(m, SMB_MASK);
    if (int'(dw) == SMB_CTL_DW && be[2]) m[23:20] = 4'h0;
    return m;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEV_DWORDS; i++) begin
        dev_q[i] <= (i == PM_B_IDX || i == SMB_B_IDX) ? 32'h1 : 32'h0;
      end
    end else if (dev_wr) begin
      dev_q[dev_idx] <= next_word(cfg_dw_addr, dev_q[dev_idx], cfg_wdata, cfg_be);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= 16'h0;
    end else if (cmd_wr) begin
      cmd_q <= merge_bytes({16'h0, cmd_q}, cfg_wdata, cfg_be & 4'b0011)[15:0];
    end
  end

  logic [31:0] rd_word;
  always_comb begin
    if (in_dev) begin
      rd_word = dev_q[dev_idx];
    end else begin
      case (int'(cfg_dw_addr))
        0:       rd_word = {DEVICE_ID, VENDOR_ID};
        1:       rd_word = {STATUS_VAL, cmd_q};
        2:       rd_word = {CLASS_CODE, REV_ID};
        default: rd_word = 32'h0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_rvalid <= 1'b0;
      cfg_rdata  <= 32'h0;
    end else begin
      cfg_rvalid <= cfg_rd;
      if (cfg_rd) cfg_rdata <= rd_word;
    end
  end

  assign pm_base  = dev_q[PM_B_IDX][15:0];
  assign smb_base = dev_q[SMB_B_IDX][15:0];
  assign pm_en    = dev_q[PM_EN_IDX][15];
  assign smb_en   = dev_q[SMB_EN_IDX][16];

endmodule

// File: rtl/pmf_win_decode.sv
module pmf_win_decode
  import pmf_pkg::*;
#(
  parameter int SPAN = 7
) (
  input  logic            en,
  input  logic [15:0]     base,
  input  logic [15:0]     io_addr,
  input  logic            strobe,
  output logic            hit,
  output logic [SPAN-1:0] offset
);
  assign hit    = en && strobe && in_window(io_addr, base, SPAN);
  assign offset = io_addr[SPAN-1:0];
endmodule

// File: rtl/pmf_base_decoder.sv
module pmf_base_decoder #(
  parameter int          CFG_DW_W    = 6,
  parameter int          HDR_DWORDS  = 16,
  parameter int          PM_SPAN     = 7,
  parameter int          SMB_SPAN    = 4,
  parameter int          PM_BASE_DW  = 18,
  parameter int          SMB_BASE_DW = 36,
  parameter int          PM_EN_DW    = 16,
  parameter int          SMB_CTL_DW  = 52,
  parameter logic [15:0] VENDOR_ID   = 16'h1D0F,
  parameter logic [15:0] DEVICE_ID   = 16'h3057,
  parameter logic [23:0] CLASS_CODE  = 24'h068000,
  parameter logic [7:0]  REV_ID      = 8'h40,
  parameter int          IO_DATA_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic                 cfg_rd,
  input  logic [CFG_DW_W-1:0]  cfg_dw_addr,
  input  logic [3:0]           cfg_be,
  input  logic [31:0]          cfg_wdata,
  output logic                 cfg_rvalid,
  output logic [31:0]          cfg_rdata,
  input  logic [15:0]          io_addr,
  input  logic                 io_rd,
  input  logic                 io_wr,
  output logic                 pm_hit,
  output logic [PM_SPAN-1:0]   pm_off,
  output logic                 smb_hit,
  output logic [SMB_SPAN-1:0]  smb_off,
  output logic [IO_DATA_W-1:0] pm_rdata
);
  logic [15:0] pm_base_w, smb_base_w;
  logic        pm_en_w, smb_en_w;
  logic        io_strobe;

  assign io_strobe = io_rd || io_wr;

  pmf_cfg_regs #(
    .CFG_DW_W(CFG_DW_W), .HDR_DWORDS(HDR_DWORDS),
    .PM_SPAN(PM_SPAN), .SMB_SPAN(SMB_SPAN),
    .PM_BASE_DW(PM_BASE_DW), .SMB_BASE_DW(SMB_BASE_DW),
    .PM_EN_DW(PM_EN_DW), .SMB_CTL_DW(SMB_CTL_DW),
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID),
    .CLASS_CODE(CLASS_CODE), .REV_ID(REV_ID),
    .STATUS_VAL(16'h0280)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_dw_addr(cfg_dw_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata),
    .pm_base(pm_base_w), .pm_en(pm_en_w),
    .smb_base(smb_base_w), .smb_en(smb_en_w)
  );

  pmf_win_decode #(.SPAN(PM_SPAN)) u_pm_dec (
    .en(pm_en_w), .base(pm_base_w), .io_addr(io_addr), .strobe(io_strobe),
    .hit(pm_hit), .offset(pm_off)
  );

  pmf_win_decode #(.SPAN(SMB_SPAN)) u_smb_dec (
    .en(smb_en_w), .base(smb_base_w), .io_addr(io_addr), .strobe(io_strobe),
    .hit(smb_hit), .offset(smb_off)
  );

  // Power-management window registers are not modelled here: reads give zero.
  assign pm_rdata = '0;

endmodule

// File: rtl/pmf_base_decoder_chk.sv
module pmf_base_decoder_chk #(
  parameter int CFG_DW_W    = 6,
  parameter int PM_BASE_DW  = 18,
  parameter int SMB_BASE_DW = 36,
  parameter int SMB_CTL_DW  = 52
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfg_wr,
  input logic                cfg_rd,
  input logic [CFG_DW_W-1:0] cfg_dw_addr,
  input logic                cfg_rvalid,
  input logic [31:0]         cfg_rdata,
  input logic [15:0]         io_addr,
  input logic                io_rd,
  input logic                io_wr,
  input logic                pm_hit,
  input logic                smb_hit
);
  assert_pm_base_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rvalid && int'($past(cfg_dw_addr)) == PM_BASE_DW
      |-> cfg_rdata[31:16] == 16'h0 && cfg_rdata[6:0] == 7'h01);

  assert_smb_base_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rvalid && int'($past(cfg_dw_addr)) == SMB_BASE_DW
      |-> cfg_rdata[31:16] == 16'h0 && cfg_rdata[3:0] == 4'h1);

  assert_smb_ctl_nibble_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rvalid && int'($past(cfg_dw_addr)) == SMB_CTL_DW |-> cfg_rdata[23:20] == 4'h0);

  assert_status_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rvalid && $past(cfg_dw_addr) == CFG_DW_W'(1) |-> cfg_rdata[31:16] == 16'h0280);

  assert_no_strobe_no_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd && !io_wr |-> !pm_hit && !smb_hit);

  assert_hit_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_wr) && $stable(io_addr) && $stable(io_rd) && $stable(io_wr)
      |-> $stable(pm_hit) && $stable(smb_hit));

  assert_rvalid_follows_rd_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd |=> cfg_rvalid);
endmodule

bind pmf_base_decoder pmf_base_decoder_chk #(
  .CFG_DW_W(CFG_DW_W), .PM_BASE_DW(PM_BASE_DW),
  .SMB_BASE_DW(SMB_BASE_DW), .SMB_CTL_DW(SMB_CTL_DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
  .cfg_dw_addr(cfg_dw_addr), .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata),
  .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
  .pm_hit(pm_hit), .smb_hit(smb_hit)
);

// File: tb/tb_pmf_base_decoder.sv
module tb_pmf_base_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [5:0]  cfg_dw_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_rvalid;
  logic [31:0] cfg_rdata;
  logic [15:0] io_addr = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic        pm_hit, smb_hit;
  logic [6:0]  pm_off;
  logic [3:0]  smb_off;
  logic [7:0]  pm_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pmf_base_decoder dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_dw_addr(cfg_dw_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata),
    .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .pm_hit(pm_hit), .pm_off(pm_off), .smb_hit(smb_hit), .smb_off(smb_off),
    .pm_rdata(pm_rdata)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever read data comes back.
  always @(negedge clk) begin
    if (rst_n && cfg_rvalid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R12 unexpected read data", cfg_rdata, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(cfg_rdata === e, t, cfg_rdata, e);
      end
    end
  end

  task automatic cfg_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_dw_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
  endtask

  task automatic cfg_expect(input logic [5:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    cfg_rd = 1'b1; cfg_dw_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    cfg_rd = 1'b0;
  endtask

  task automatic io_probe(input logic [15:0] a, input bit rd, input bit wr,
                          input bit e_pm, input logic [6:0] e_pm_off,
                          input bit e_smb, input logic [3:0] e_smb_off,
                          input string tag);
    @(negedge clk);
    io_addr = a; io_rd = rd; io_wr = wr;
    #1;
    check(pm_hit === e_pm, {tag, " pm_hit"}, {31'h0, pm_hit}, {31'h0, e_pm});
    if (e_pm) begin
      check(pm_off === e_pm_off, {tag, " pm_off"}, {25'h0, pm_off}, {25'h0, e_pm_off});
      if (rd) check(pm_rdata === 8'h00, "R8 pm read data", {24'h0, pm_rdata}, 32'h0);
    end
    check(smb_hit === e_smb, {tag, " smb_hit"}, {31'h0, smb_hit}, {31'h0, e_smb});
    if (e_smb)
      check(smb_off === e_smb_off, {tag, " smb_off"}, {28'h0, smb_off}, {28'h0, e_smb_off});
    @(negedge clk);
    io_rd = 1'b0; io_wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    cfg_expect(6'h12, 32'h0000_0001, "R1 pm base reset");
    cfg_expect(6'h24, 32'h0000_0001, "R1 smb base reset");
    cfg_expect(6'h10, 32'h0000_0000, "R1 dword 0x40 reset");
    cfg_expect(6'h34, 32'h0000_0000, "R1 dword 0xD0 reset");
    io_probe(16'h0000, 1, 0, 0, 0, 0, 0, "R1 no hit after reset");

    // R2 header
    cfg_expect(6'h00, 32'h3057_1D0F, "R2 id dword");
    cfg_expect(6'h02, 32'h0680_0040, "R2 class dword");
    cfg_expect(6'h01, 32'h0280_0000, "R2 status after reset");
    cfg_write(6'h01, 4'hF, 32'hFFFF_0007);
    cfg_expect(6'h01, 32'h0280_0007, "R2 command writable, status fixed");
    cfg_write(6'h00, 4'hF, 32'hFFFF_FFFF);
    cfg_expect(6'h00, 32'h3057_1D0F, "R2 id write ignored");
    cfg_write(6'h03, 4'hF, 32'hFFFF_FFFF);
    cfg_expect(6'h03, 32'h0000_0000, "R2 header write ignored");

    // R3 pm base cleanup
    cfg_write(6'h12, 4'hF, 32'hDEAD_BEEF);
    cfg_expect(6'h12, 32'h0000_BE81, "R3 pm base full write");
    cfg_write(6'h12, 4'h1, 32'h0000_00FF);
    cfg_expect(6'h12, 32'h0000_BE81, "R3 pm base low byte write");
    cfg_write(6'h12, 4'hF, 32'h0000_4000);
    cfg_expect(6'h12, 32'h0000_4001, "R3 pm base relocate");

    // R6 disabled window, then enable
    io_probe(16'h4005, 1, 0, 0, 0, 0, 0, "R6 pm disabled");
    cfg_write(6'h10, 4'h2, 32'h0000_8000);
    io_probe(16'h4005, 1, 0, 1, 7'h05, 0, 0, "R10 pm enable next cycle");
    io_probe(16'h407F, 1, 0, 1, 7'h7F, 0, 0, "R6 pm last byte");
    io_probe(16'h4080, 1, 0, 0, 0, 0, 0, "R6 pm past end");
    io_probe(16'h3FFF, 1, 0, 0, 0, 0, 0, "R6 pm below base");
    io_probe(16'h4005, 0, 0, 0, 0, 0, 0, "R11 no strobe");
    io_probe(16'h4010, 0, 1, 1, 7'h10, 0, 0, "R8 pm write hit");
    cfg_expect(6'h12, 32'h0000_4001, "R8 pm write no effect on base");
    cfg_expect(6'h10, 32'h0000_8000, "R8 pm write no effect on enable");

    // R4 smb base cleanup
    cfg_write(6'h24, 4'hF, 32'h1234_5678);
    cfg_expect(6'h24, 32'h0000_5671, "R4 smb base full write");
    cfg_write(6'h24, 4'hF, 32'h0000_5000);

    // R5 / R9 / R7
    cfg_write(6'h34, 4'h4, 32'h00FF_0000);
    cfg_expect(6'h34, 32'h000F_0000, "R5 byte 0xD2 low nibble");
    cfg_write(6'h34, 4'hB, 32'hFFFF_FFFF);
    cfg_expect(6'h34, 32'hFF0F_FFFF, "R9 byte enables around 0xD2");
    io_probe(16'h500F, 1, 0, 0, 0, 1, 4'hF, "R7 smb last byte");
    io_probe(16'h5000, 0, 1, 0, 0, 1, 4'h0, "R7 smb first byte write");
    io_probe(16'h5010, 1, 0, 0, 0, 0, 0, "R7 smb past end");
    cfg_write(6'h34, 4'h4, 32'h0000_0000);
    io_probe(16'h5003, 1, 0, 0, 0, 0, 0, "R10 smb disable next cycle");

    // R9 plain device dword
    cfg_write(6'h20, 4'h5, 32'hAABB_CCDD);
    cfg_expect(6'h20, 32'h00BB_00DD, "R9 partial write");

    // R10 relocation and pm disable
    cfg_write(6'h12, 4'h2, 32'h0000_8000);
    io_probe(16'h8002, 1, 0, 1, 7'h02, 0, 0, "R10 pm relocate next cycle");
    cfg_write(6'h10, 4'h2, 32'h0000_0000);
    io_probe(16'h8002, 1, 0, 0, 0, 0, 0, "R6 pm disabled again");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R12 all reads returned", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule